// File: doc/BRIEF.md
# Multi-Source Interrupt Status Controller

This block gathers six interrupt sources into one status word and drives a single interrupt line to the processor. Two of the sources are external pins that the status follows as levels: one is active low and one is active high. The other four are events that stay latched until software clears them. These are an underflow event for each of two timers, a change on either of two modem handshake lines, and the completion of a transfer on a synchronous serial link. Software clears each event source in a fixed way. A timer or modem event is cleared by writing to its own end-of-interrupt address. The transfer event is cleared by reading the received data word.

A small register bus carries these accesses. Every pin from outside the clock domain passes through a synchronizer before it is used. A timer underflow is taken only on a falling edge of that timer's own clock, which the block detects by sampling the synchronized timer clock with the system clock. A per-source mask register selects which status bits drive the interrupt output. The timers, the serial port and the converter link are not part of this block. They reach it only as pins and event strobes.

Top module: `irq_status_ctrl`

Status bit positions: bit 0 active-low pin, bit 1 active-high pin, bits 2 and 3 timer 0 and timer 1, bit 4 modem lines, bit 5 transfer done. Register addresses: 0 raw status (read), 1 mask (read/write), 2 masked status (read), 3 timer-0 end-of-interrupt (write), 4 timer-1 end-of-interrupt (write), 5 modem end-of-interrupt (write), 6 transfer data (read).

## Requirements
- R1: Status bit 0 is the inverse of `ext_lo_n_i` after the two-flop synchronizer. It is not latched, so it returns to 0 when the pin returns high.
- R2: Status bit 1 follows `ext_hi_i` after the synchronizer. It is not latched.
- R3: Status bit 2+n sets when the synchronized `tmr_clk_i[n]` falls while the synchronized `tmr_uflow_i[n]` is high. A rising edge of the timer clock never sets it.
- R4: A timer bit is cleared only by a bus write to its own end-of-interrupt address (3 for timer 0, 4 for timer 1), whatever the write data. A write to the other timer's address leaves the bit set.
- R5: Status bit 4 sets when either synchronized `cts_i` or `dsr_i` changes, in either direction. It is cleared by a write to address 5.
- R6: Status bit 5 sets on the clock edge that samples `xfer_done_i` high. A read of address 6 returns `xfer_data_i` and clears the bit.
- R7: When an event sets in the same cycle that its clear access happens, the bit stays set.
- R8: A read of address 0 returns the raw status word, zero-extended. Address 1 is the mask register, which can be written and read back. A read of address 2 returns status AND mask. Other addresses, and any cycle without a read, return 0.
- R9: `irq_o` is the OR of all status bits whose mask bit is set.
- R10: Synchronous reset clears every latched bit and the mask and drives `irq_o` low. It also sets the synchronizer of the active-low pin to its inactive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lo_n_i | input | 1 | External interrupt pin, active low |
| ext_hi_i | input | 1 | External interrupt pin, active high |
| tmr_clk_i | input | TMR_N | Clock of each timer |
| tmr_uflow_i | input | TMR_N | High while the timer counter is at zero |
| cts_i | input | 1 | Modem clear-to-send line |
| dsr_i | input | 1 | Modem data-set-ready line |
| xfer_done_i | input | 1 | One-cycle strobe when a serial transfer ends |
| xfer_data_i | input | DATA_W | Word received by the serial link |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | REG_AW | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions check several properties on every cycle:
- Each level bit equals its pin as it stood two edges earlier.
- Every latched bit falls only after its own clear access.
- A transfer strobe always leaves bit 5 set on the next cycle, even when a clearing read coincides with it.
- The interrupt output always matches the masked status.

Some behaviours can only be shown by the bench's scenarios:
- A rising timer clock does not set a timer bit, and only the falling edge does.
- A modem change sets bit 4 in both directions.
- A write to the wrong end-of-interrupt address leaves a bit set.
- The data register returns the received word.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int SRC_N  = 6;
    localparam int TMR_N  = 2;
    localparam int EVT_N  = TMR_N + 2;
    localparam int REG_AW = 3;

    localparam int B_EXTLO = 0;
    localparam int B_EXTHI = 1;
    localparam int B_TMR0  = 2;
    localparam int B_MDM   = B_TMR0 + TMR_N;
    localparam int B_XFER  = B_MDM + 1;

    typedef enum logic [REG_AW-1:0] {
        RA_STAT    = 3'd0,
        RA_MASK    = 3'd1,
        RA_MSTAT   = 3'd2,
        RA_EOI_T0  = 3'd3,
        RA_EOI_T1  = 3'd4,
        RA_EOI_MDM = 3'd5,
        RA_XDATA   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [REG_AW-1:0] addr;
    } bus_cmd_t;

    // One bit per latched event source, the same layout for set and clear
    typedef struct packed {
        logic             xfer;
        logic             mdm;
        logic [TMR_N-1:0] tmr;
    } evt_t;

    function automatic logic [SRC_N-1:0] pack_status(logic lo_act, logic hi_act, evt_t lat);
        return {lat.xfer, lat.mdm, lat.tmr, hi_act, lo_act};
    endfunction

    function automatic logic hits(bus_cmd_t c, logic is_wr, reg_addr_e a);
        return (is_wr ? c.wr : c.rd) && (c.addr == a);
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q;

    // Set dominates clear so a coincident event survives
    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)           q[b] <= 1'b0;
                else if (set_i[b]) q[b] <= 1'b1;
                else if (clr_i[b]) q[b] <= 1'b0;
            end
        end
    endgenerate

    assign q_o = q;
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  status_i,
    input  logic [DATA_W-1:0] xdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output evt_t              clr_o,
    output logic [SRC_N-1:0]  mask_o,
    output logic              irq_o
);
    logic [SRC_N-1:0] mask_q;
    logic [SRC_N-1:0] masked;

    always_ff @(posedge clk) begin
        if (rst)                          mask_q <= '0;
        else if (hits(cmd_i, 1'b1, RA_MASK)) mask_q <= wdata_i[SRC_N-1:0];
    end

    assign masked = status_i & mask_q;

    always_comb begin
        clr_o        = '0;
        clr_o.tmr[0] = hits(cmd_i, 1'b1, RA_EOI_T0);
        clr_o.tmr[1] = hits(cmd_i, 1'b1, RA_EOI_T1);
        clr_o.mdm    = hits(cmd_i, 1'b1, RA_EOI_MDM);
        clr_o.xfer   = hits(cmd_i, 1'b0, RA_XDATA);
    end

    always_comb begin
        rdata_o = '0;
        if (cmd_i.rd) begin
            case (cmd_i.addr)
                RA_STAT:  rdata_o = DATA_W'(status_i);
                RA_MASK:  rdata_o = DATA_W'(mask_q);
                RA_MSTAT: rdata_o = DATA_W'(masked);
                RA_XDATA: rdata_o = xdata_i;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = |masked;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_lo_n_i,
    input  logic              ext_hi_i,
    input  logic [TMR_N-1:0]  tmr_clk_i,
    input  logic [TMR_N-1:0]  tmr_uflow_i,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              xfer_done_i,
    input  logic [DATA_W-1:0] xfer_data_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int           ASYNC_W = 4 + 2 * TMR_N;
    localparam int           O_TCLK  = 2;
    localparam int           O_TUF   = O_TCLK + TMR_N;
    localparam int           O_MDM   = O_TUF + TMR_N;
    localparam logic [ASYNC_W-1:0] ASYNC_RST = ASYNC_W'(1);

    logic [ASYNC_W-1:0] async_raw, async_s;
    logic [TMR_N-1:0]   tclk_s, tuf_s, tclk_d;
    logic [1:0]         mdm_s, mdm_d;
    evt_t               ev_set, ev_clr, ev_lat;
    logic [SRC_N-1:0]   status;
    logic [SRC_N-1:0]   mask_q;
    bus_cmd_t           cmd;

    assign async_raw = {dsr_i, cts_i, tmr_uflow_i, tmr_clk_i, ext_hi_i, ext_lo_n_i};

    irq_sync2 #(
        .W       (ASYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (ASYNC_RST)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (async_raw),
        .q   (async_s)
    );

    assign tclk_s = async_s[O_TCLK +: TMR_N];
    assign tuf_s  = async_s[O_TUF  +: TMR_N];
    assign mdm_s  = async_s[O_MDM  +: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_d <= '0;
            mdm_d  <= '0;
        end else begin
            tclk_d <= tclk_s;
            mdm_d  <= mdm_s;
        end
    end

    generate
        for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
            assign ev_set.tmr[t] = tclk_d[t] & ~tclk_s[t] & tuf_s[t];
        end
    endgenerate

    assign ev_set.mdm  = |(mdm_d ^ mdm_s);
    assign ev_set.xfer = xfer_done_i;

    irq_evt_latch #(
        .N (EVT_N)
    ) latch_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev_set),
        .clr_i (ev_clr),
        .q_o   (ev_lat)
    );

    assign status = pack_status(~async_s[0], async_s[1], ev_lat);

    assign cmd.wr   = bus_wr_i;
    assign cmd.rd   = bus_rd_i;
    assign cmd.addr = bus_addr_i;

    irq_regbus #(
        .DATA_W (DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .wdata_i  (bus_wdata_i),
        .status_i (status),
        .xdata_i  (xfer_data_i),
        .rdata_o  (bus_rdata_o),
        .clr_o    (ev_clr),
        .mask_o   (mask_q),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_lo_n_i,
    input logic              ext_hi_i,
    input logic              xfer_done_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [REG_AW-1:0] bus_addr_i,
    input logic [SRC_N-1:0]  status,
    input logic [SRC_N-1:0]  mask_q,
    input logic              irq_o
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 3)  cyc <= cyc + 2'd1;
    end

    p_extlo_follows_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2) |-> (status[B_EXTLO] == !$past(ext_lo_n_i, 2)));

    p_exthi_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2) |-> (status[B_EXTHI] == $past(ext_hi_i, 2)));

    p_tmr0_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc != 0 && $fell(status[B_TMR0])) |-> $past(bus_wr_i && bus_addr_i == RA_EOI_T0));

    p_tmr1_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc != 0 && $fell(status[B_TMR0+1])) |-> $past(bus_wr_i && bus_addr_i == RA_EOI_T1));

    p_mdm_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc != 0 && $fell(status[B_MDM])) |-> $past(bus_wr_i && bus_addr_i == RA_EOI_MDM));

    p_xfer_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc != 0 && $fell(status[B_XFER])) |-> $past(bus_rd_i && bus_addr_i == RA_XDATA));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc != 0 && $past(xfer_done_i)) |-> status[B_XFER]);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(status & mask_q));
endmodule

bind irq_status_ctrl irq_status_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ext_lo_n_i  (ext_lo_n_i),
    .ext_hi_i    (ext_hi_i),
    .xfer_done_i (xfer_done_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .status      (status),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;
    import irq_pkg::*;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ext_lo_n = 1'b1;
    logic              ext_hi = 1'b0;
    logic [TMR_N-1:0]  tclk = '0;
    logic [TMR_N-1:0]  tuf = '0;
    logic              cts = 1'b0;
    logic              dsr = 1'b0;
    logic              xdone = 1'b0;
    logic [DATA_W-1:0] xdata = 8'h3C;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [REG_AW-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.DATA_W(DATA_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ext_lo_n_i  (ext_lo_n),
        .ext_hi_i    (ext_hi),
        .tmr_clk_i   (tclk),
        .tmr_uflow_i (tuf),
        .cts_i       (cts),
        .dsr_i       (dsr),
        .xfer_done_i (xdone),
        .xfer_data_i (xdata),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic       lo_n;
        logic       hi;
        logic [5:0] mask;
        logic [5:0] stat;
        logic       irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 6'h00, 6'h00, 1'b0},
        '{1'b0, 1'b0, 6'h3F, 6'h01, 1'b1},
        '{1'b1, 1'b1, 6'h01, 6'h02, 1'b0},
        '{1'b0, 1'b1, 6'h02, 6'h03, 1'b1},
        '{1'b0, 1'b1, 6'h3C, 6'h03, 1'b0},
        '{1'b1, 1'b0, 6'h3F, 6'h00, 1'b0}
    };

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [REG_AW-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_read(logic [REG_AW-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; addr = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        bus_read(RA_STAT, r);  check("R10 status", r, 8'h00);
        bus_read(RA_MASK, r);  check("R10 mask", r, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);

        // Level pins and masks, table driven (R1 R2 R8 R9)
        foreach (VECS[i]) begin
            bus_write(RA_MASK, {2'b00, VECS[i].mask});
            @(negedge clk);
            ext_lo_n = VECS[i].lo_n;
            ext_hi   = VECS[i].hi;
            settle();
            bus_read(RA_STAT, r);  check("R1 R2 status", r, {2'b00, VECS[i].stat});
            bus_read(RA_MSTAT, r); check("R8 masked", r, {2'b00, VECS[i].stat & VECS[i].mask});
            check("R9 irq", {7'd0, irq}, {7'd0, VECS[i].irq});
        end
        bus_read(RA_MASK, r); check("R8 mask readback", r, 8'h3F);
        bus_read(3'd7, r);    check("R8 unused addr", r, 8'h00);

        // R3 timer 0: rising edge must not set, falling edge sets
        @(negedge clk); tuf[0] = 1'b1; tclk[0] = 1'b1;
        settle();
        bus_read(RA_STAT, r); check("R3 no set on rise", r, 8'h00);
        @(negedge clk); tclk[0] = 1'b0;
        settle();
        @(negedge clk); tuf[0] = 1'b0;
        bus_read(RA_STAT, r); check("R3 set on fall", r, 8'h04);
        check("R9 irq timer", {7'd0, irq}, 8'h01);
        // R4 wrong EOI keeps it, own EOI clears whatever the data
        bus_write(RA_EOI_T1, 8'hFF);
        bus_read(RA_STAT, r); check("R4 other EOI", r, 8'h04);
        bus_write(RA_EOI_T0, 8'hA5);
        bus_read(RA_STAT, r); check("R4 own EOI", r, 8'h00);
        // Timer 1, falling edge without underflow does nothing
        @(negedge clk); tclk[1] = 1'b1;
        settle();
        @(negedge clk); tclk[1] = 1'b0;
        settle();
        bus_read(RA_STAT, r); check("R3 fall without underflow", r, 8'h00);
        @(negedge clk); tuf[1] = 1'b1; tclk[1] = 1'b1;
        settle();
        @(negedge clk); tclk[1] = 1'b0;
        settle();
        @(negedge clk); tuf[1] = 1'b0;
        bus_read(RA_STAT, r); check("R3 timer1 set", r, 8'h08);
        bus_write(RA_EOI_T1, 8'h00);
        bus_read(RA_STAT, r); check("R4 timer1 clear", r, 8'h00);

        // R5 modem lines, both directions
        @(negedge clk); cts = 1'b1;
        settle();
        bus_read(RA_STAT, r); check("R5 cts rise", r, 8'h10);
        bus_write(RA_EOI_MDM, 8'h00);
        bus_read(RA_STAT, r); check("R5 clear", r, 8'h00);
        @(negedge clk); dsr = 1'b1;
        settle();
        bus_read(RA_STAT, r); check("R5 dsr rise", r, 8'h10);
        bus_write(RA_EOI_MDM, 8'h00);
        @(negedge clk); dsr = 1'b0;
        settle();
        bus_read(RA_STAT, r); check("R5 dsr fall", r, 8'h10);
        bus_write(RA_EOI_MDM, 8'h00);
        bus_read(RA_STAT, r); check("R5 clear again", r, 8'h00);

        // R6 transfer done
        @(negedge clk); xdone = 1'b1;
        @(negedge clk); xdone = 1'b0;
        bus_read(RA_STAT, r); check("R6 set", r, 8'h20);
        bus_write(RA_EOI_MDM, 8'h00);
        bus_read(RA_STAT, r); check("R6 not cleared by EOI", r, 8'h20);
        bus_read(RA_XDATA, r); check("R6 data", r, 8'h3C);
        bus_read(RA_STAT, r); check("R6 clear on read", r, 8'h00);

        // R7 set and clear in the same cycle
        @(negedge clk); xdone = 1'b1; rd = 1'b1; addr = RA_XDATA;
        @(negedge clk); xdone = 1'b0; rd = 1'b0; addr = '0;
        bus_read(RA_STAT, r); check("R7 set wins", r, 8'h20);

        // R10 reset in the middle of activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(RA_STAT, r); check("R10 status after reset", r, 8'h00);
        bus_read(RA_MASK, r); check("R10 mask after reset", r, 8'h00);
        check("R10 irq after reset", {7'd0, irq}, 8'h00);

        finish_run();
    end
endmodule